// File: doc/BRIEF.md
# Serial-to-Parallel Latched Output Driver

This block is the logic core of a cascadable display driver. Bits arrive on a slow serial data line. They are shifted into a register of `WIDTH` stages, one stage for each falling edge of a serial clock. A load input copies the register into a bank of output latches. The latch stage is transparent while load is high and holds its contents while load is low. Each latched bit then passes through a sense/force stage that produces one channel-enable bit. A 1 on a channel enable means that channel sinks current.

A serial output always shows the register stage that is furthest from the entry point. Several blocks can therefore be chained by wiring that output to the next block's data input. A direction input picks the end of the register where new bits enter.

All serial-side inputs are asynchronous to the system clock. The block brings them in through two-flop synchronizers, and a falling-edge detect on the synchronized serial clock produces the shift strobe. The sense and force inputs are static levels and act combinationally on the channel outputs.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous reset clears the shift register and the latches to zero, so the serial output reads 0 and, with force_n high and sense high, every channel reads 0.
- R2: The shift register moves by exactly one stage for each falling edge of the serial clock input. The change is visible no more than four system-clock cycles after that edge. A rising edge or a steady clock leaves the register unchanged.
- R3: With rev low (forward), each new bit enters stage 0, every stage k moves to stage k+1, and the serial output shows stage WIDTH-1. A word sent most-significant bit first therefore lands with bit i in stage i.
- R4: With rev high (reverse), each new bit enters stage WIDTH-1, every stage k moves to stage k-1, and the serial output shows stage 0. A word sent least-significant bit first therefore lands with bit i in stage i.
- R5: The load, force_n and sense inputs have no effect on the contents of the shift register.
- R6: While load is high, the latches follow the shift register, trailing it by at most four system-clock cycles.
- R7: While load is low, the latches keep their value whatever the shift register does.
- R8: With force_n low, every channel output equals the inverse of sense: all channels are on when sense is 0 and all are off when sense is 1.
- R9: With force_n high, channel i equals latch bit i when sense is 1 and its inverse when sense is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial interface |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock; the register shifts on its falling edge |
| ser_din_i | input | 1 | Serial data input |
| load_i | input | 1 | Latch load; high makes the latches transparent |
| force_n_i | input | 1 | Active-low override that drives all channels to one state |
| sense_i | input | 1 | Output sense: 1 passes latch bits true, 0 inverts them |
| rev_i | input | 1 | Shift direction: 0 forward, 1 reverse |
| ser_dout_o | output | 1 | Cascade output showing the last stage for the current direction |
| chan_on_o | output | WIDTH | Channel enables, 1 means the channel sinks |

## Verification
The bench sends whole words in both directions. It then checks that each one lands with bit i in stage i. A design that mirrored the entry end, or took the cascade output from the wrong end, would scramble those words or show the first bit of the word instead of the last stage. It also raises the serial clock without lowering it, to catch a design that shifts on the wrong edge. It toggles force and sense during a transfer, to catch any leak of the output controls into the shift path. Separate checks shift new data with load low, which exposes latches that follow the register instead of holding. Others run with load held high, which exposes latches that only capture on an edge of load.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;

    // Entry end of the shift register
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } shift_dir_e;

    // Static output controls
    typedef struct packed {
        logic force_n;
        logic sense;
    } out_ctl_t;

    localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/sdrv_sync.sv
module sdrv_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdrv_shift.sv
module sdrv_shift
    import sdrv_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             din_s,
    input  shift_dir_e       dir,
    output logic             strobe,
    output logic [WIDTH-1:0] bits_q,
    output logic             tail
);
    typedef struct packed {
        logic [WIDTH-1:0] sreg;
        logic             clk_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;

    // R2: one-cycle strobe on a high-to-low step of the synced serial clock
    assign strobe = st_q.clk_prev & ~sclk_s;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sclk_s;
        if (strobe) begin
            // R3 / R4: entry end chosen by direction
            if (dir == DIR_REV) st_d.sreg = {din_s, st_q.sreg[WIDTH-1:1]};
            else                st_d.sreg = {st_q.sreg[WIDTH-2:0], din_s};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;   // R1
        else     st_q <= st_d;
    end

    assign bits_q = st_q.sreg;
    assign tail   = (dir == DIR_REV) ? st_q.sreg[0] : st_q.sreg[WIDTH-1];
endmodule

// File: rtl/sdrv_latch_out.sv
module sdrv_latch_out
    import sdrv_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_s,
    input  logic [WIDTH-1:0] bits_in,
    input  out_ctl_t         ctl,
    output logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] chan_on
);
    logic [WIDTH-1:0] hold_d;

    // R6 / R7: transparent while load is high, holding otherwise
    always_comb begin
        hold_d = hold_q;
        if (load_s) hold_d = bits_in;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;   // R1
        else     hold_q <= hold_d;
    end

    // R8 / R9: per-channel sense and force gating
    for (genvar g = 0; g < int'(WIDTH); g++) begin : g_chan
        always_comb begin
            if (!ctl.force_n) chan_on[g] = ~ctl.sense;
            else              chan_on[g] = ctl.sense ? hold_q[g] : ~hold_q[g];
        end
    end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
    import sdrv_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_din_i,
    input  logic             load_i,
    input  logic             force_n_i,
    input  logic             sense_i,
    input  logic             rev_i,
    output logic             ser_dout_o,
    output logic [WIDTH-1:0] chan_on_o
);
    localparam int unsigned NSYNC = 3;

    logic [NSYNC-1:0] raw_in, synced;
    logic             sclk_s, din_s, load_s;
    logic             shift_stb;
    logic [WIDTH-1:0] shift_bits, latch_bits;
    out_ctl_t         ctl;

    assign raw_in = {ser_clk_i, ser_din_i, load_i};

    sdrv_sync #(.W(NSYNC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    assign {sclk_s, din_s, load_s} = synced;

    sdrv_shift #(.WIDTH(WIDTH)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (sclk_s),
        .din_s  (din_s),
        .dir    (shift_dir_e'(rev_i)),
        .strobe (shift_stb),
        .bits_q (shift_bits),
        .tail   (ser_dout_o)
    );

    assign ctl.force_n = force_n_i;
    assign ctl.sense   = sense_i;

    sdrv_latch_out #(.WIDTH(WIDTH)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load_s  (load_s),
        .bits_in (shift_bits),
        .ctl     (ctl),
        .hold_q  (latch_bits),
        .chan_on (chan_on_o)
    );
endmodule

// File: rtl/serial_latch_driver_chk.sv
module serial_latch_driver_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             rev_i,
    input logic             force_n_i,
    input logic             sense_i,
    input logic             ser_dout_o,
    input logic [WIDTH-1:0] chan_on_o,
    input logic             shift_stb,
    input logic             din_s,
    input logic             load_s,
    input logic [WIDTH-1:0] shift_bits,
    input logic [WIDTH-1:0] latch_bits
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (shift_bits == '0 && latch_bits == '0 && !ser_dout_o));

    // R2
    no_strobe_no_move_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_stb |=> $stable(shift_bits));

    // R3
    fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_stb && !rev_i) |=>
            (shift_bits[0] == $past(din_s)) &&
            (shift_bits[WIDTH-1:1] == $past(shift_bits[WIDTH-2:0])));

    // R4
    rev_step_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_stb && rev_i) |=>
            (shift_bits[WIDTH-1] == $past(din_s)) &&
            (shift_bits[WIDTH-2:0] == $past(shift_bits[WIDTH-1:1])));

    // R6
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        load_s |=> latch_bits == $past(shift_bits));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_s |=> $stable(latch_bits));

    // R8
    forced_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_n_i && sense_i) |-> chan_on_o == '0);

    // R8
    forced_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_n_i && !sense_i) |-> &chan_on_o);
endmodule

bind serial_latch_driver serial_latch_driver_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rev_i      (rev_i),
    .force_n_i  (force_n_i),
    .sense_i    (sense_i),
    .ser_dout_o (ser_dout_o),
    .chan_on_o  (chan_on_o),
    .shift_stb  (shift_stb),
    .din_s      (din_s),
    .load_s     (load_s),
    .shift_bits (shift_bits),
    .latch_bits (latch_bits)
);

// File: tb/test_serial_latch_driver.sv
module test_serial_latch_driver;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0, ser_din = 1'b0, load = 1'b0;
    logic         force_n = 1'b1, sense = 1'b1, rev = 1'b0;
    logic         dout;
    logic [W-1:0] chan;
    int           total = 0, bad = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    serial_latch_driver #(.WIDTH(W)) i_serial_latch_driver (
        .clk        (clk),
        .rst        (rst),
        .ser_clk_i  (ser_clk),
        .ser_din_i  (ser_din),
        .load_i     (load),
        .force_n_i  (force_n),
        .sense_i    (sense),
        .rev_i      (rev),
        .ser_dout_o (dout),
        .chan_on_o  (chan)
    );

    typedef struct packed {
        logic [31:0] word;
        logic        rv;
        logic        sn;
        logic        fn;
        logic [31:0] exp_chan;
        logic        exp_dout;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{32'hA5A5_0F0F, 1'b0, 1'b1, 1'b1, 32'hA5A5_0F0F, 1'b1},
        '{32'h1234_5678, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 1'b0},
        '{32'h8000_0001, 1'b0, 1'b0, 1'b1, 32'h7FFF_FFFE, 1'b1},
        '{32'hFFFF_0000, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
        '{32'h0000_FFFF, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
        '{32'hC000_0003, 1'b1, 1'b1, 1'b1, 32'hC000_0003, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(4);
    endtask

    // forward: MSB first; reverse: LSB first -> bit i ends in stage i
    task automatic send_word(input logic [31:0] w, input logic r);
        rev = r;
        if (!r) for (int i = 31; i >= 0; i--) send_bit(w[i]);
        else    for (int i = 0; i < 32; i++)  send_bit(w[i]);
    endtask

    task automatic pulse_load();
        load = 1'b1;
        tick(6);
        load = 1'b0;
        tick(4);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        chk("R1 chan after reset", chan, 32'h0);
        chk("R1 dout after reset", {31'd0, dout}, 32'h0);

        // Table walk: R3 / R4 / R8 / R9
        foreach (VECS[k]) begin
            force_n = 1'b1;
            sense   = 1'b1;
            send_word(VECS[k].word, VECS[k].rv);
            pulse_load();
            force_n = VECS[k].fn;
            sense   = VECS[k].sn;
            tick(1);
            chk(VECS[k].fn ? "R9 vector chan" : "R8 vector chan", chan, VECS[k].exp_chan);
            chk(VECS[k].rv ? "R4 vector dout" : "R3 vector dout", {31'd0, dout}, {31'd0, VECS[k].exp_dout});
        end

        // R3 cascade: forward tail walks down through the word
        force_n = 1'b1; sense = 1'b1;
        send_word(32'hA5A5_0F0F, 1'b0);
        chk("R3 tail k0", {31'd0, dout}, 32'd1);
        send_bit(1'b0);
        chk("R3 tail k1", {31'd0, dout}, 32'd0);
        send_bit(1'b0);
        chk("R3 tail k2", {31'd0, dout}, 32'd1);
        send_bit(1'b0);
        chk("R3 tail k3", {31'd0, dout}, 32'd0);

        // R4 cascade: reverse tail walks up through the word
        send_word(32'h1234_5678, 1'b1);
        chk("R4 tail k0", {31'd0, dout}, 32'd0);
        send_bit(1'b0);
        chk("R4 tail k1", {31'd0, dout}, 32'd0);
        send_bit(1'b0);
        send_bit(1'b0);
        chk("R4 tail k3", {31'd0, dout}, 32'd1);

        // R6 transparent latch and R2 edge sensitivity
        do_reset();
        rev = 1'b0; load = 1'b1; force_n = 1'b1; sense = 1'b1;
        tick(4);
        send_bit(1'b1);
        tick(2);
        chk("R6 follow 1 bit", chan, 32'h1);
        send_bit(1'b0);
        tick(2);
        chk("R6 follow 2 bits", chan, 32'h2);
        ser_din = 1'b1;
        ser_clk = 1'b1;
        tick(8);
        chk("R2 rising edge no shift", chan, 32'h2);
        ser_clk = 1'b0;
        tick(6);
        chk("R2 falling edge shifts", chan, 32'h5);

        // R7 hold while load low
        load = 1'b0;
        tick(4);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        chk("R7 latches hold", chan, 32'h5);
        pulse_load();
        chk("R7 then load picks up", chan, 32'h5FF);

        // R5 controls toggled during a transfer do not disturb shifting
        do_reset();
        rev = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            force_n = i[0];
            sense   = i[1];
            load    = i[2];
            send_bit(W'(32'h3C96_E10B) >> i);
        end
        load = 1'b0; force_n = 1'b1; sense = 1'b1;
        tick(4);
        pulse_load();
        chk("R5 word intact", chan, 32'h3C96_E10B);
        chk("R5 tail intact", {31'd0, dout}, 32'd0);

        // R1 reset mid-operation
        do_reset();
        chk("R1 latches cleared", chan, 32'h0);
        sense = 1'b0;
        tick(1);
        chk("R1 inverted view all on", chan, 32'hFFFF_FFFF);
        chk("R1 dout cleared", {31'd0, dout}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL timeout in R-sequence actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule